// File: doc/BRIEF.md
# Scaled Fast Clock Follower

This block keeps a local copy of an accelerated "layout time" that runs faster than real time by a loadable factor and follows a clock shared over a network. A one-cycle real-time tick drives it. Each tick adds the current rate to a sub-minute phase accumulator. When that accumulator reaches the number of ticks in one real minute, one fast minute passes and the remainder is kept. Minutes roll into hours, and hours roll into a day count.

A sync port loads a complete clock state: the rate, the minute and hour in a 256-minus encoding, the day count, a control byte and a two-byte setter identity. A sync is adopted only when its validity bit is set. On an accepted sync the phase accumulator is cleared, so every follower on the network restarts its sub-minute phase together. The block presents the time as plain binary minute, hour and day values. It also returns the stored encoded bytes and the setter identity for read-back, with two flags that classify that identity.

Top module: `fast_clock_follower`

## Requirements
- R1: After reset the rate is 0, the time is 00:00 on day 0, both encoded bytes read 0x00, both identity bytes are 0, and never_set_o is 1.
- R2: With a nonzero rate r, each tick adds r to a phase accumulator that starts at 0 after a sync. Exactly one minute passes each time the accumulator reaches TICKS_PER_MIN, and the excess is kept. After n ticks, floor(n*r/TICKS_PER_MIN) minutes have passed, whatever idle cycles lie between the ticks.
- R3: With a rate of 0, ticks have no effect: the time and the phase stay unchanged.
- R4: Minute 59 advances to minute 0 and carries into the hour. Hour 23 advances to hour 0 and carries into the day count. The day count wraps modulo 2^DAY_W.
- R5: The encoded minute and hour bytes equal (256 - value) mod 256. Examples: minute 0 reads 0x00, minute 1 reads 0xFF, minute 59 reads 0xC5, hour 23 reads 0xE9.
- R6: A sync with bit 6 of the control byte at 1 sets, from the next cycle, the rate, minute, hour, day and identity to the sync values and clears the phase. A tick in the same cycle as the sync is discarded.
- R7: A sync with bit 6 of the control byte at 0 changes nothing: the rate, time, encoded bytes and identity all keep their values.
- R8: A synced minute byte that decodes ((256 - byte) mod 256) to more than 59 is loaded as minute 59. A synced hour byte that decodes to more than 23 is loaded as hour 23.
- R9: never_set_o is 1 exactly when both identity bytes are 0. pc_setter_o is 1 exactly when the high identity byte is 0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle real-time tick |
| sync_vld_i | input | 1 | Sync load strobe |
| sync_rate_i | input | RATE_W | Rate multiplier carried by the sync |
| sync_min_enc_i | input | 8 | Minute, 256-minus encoded |
| sync_hr_enc_i | input | 8 | Hour, 256-minus encoded |
| sync_day_i | input | DAY_W | Day count |
| sync_ctl_i | input | 8 | Control byte; bit 6 marks a valid sync |
| sync_id_lo_i | input | 7 | Setter identity, low byte |
| sync_id_hi_i | input | 7 | Setter identity, high byte |
| rate_o | output | RATE_W | Current rate |
| minute_o | output | 6 | Binary minute 0..59 |
| hour_o | output | 5 | Binary hour 0..23 |
| day_o | output | DAY_W | Day count |
| min_enc_o | output | 8 | Stored encoded minute byte |
| hr_enc_o | output | 8 | Stored encoded hour byte |
| id_lo_o | output | 7 | Stored setter identity, low byte |
| id_hi_o | output | 7 | Stored setter identity, high byte |
| never_set_o | output | 1 | Identity is all zero |
| pc_setter_o | output | 1 | Identity high byte is 0x7F |

## Verification
On every cycle the assertions check these properties:
- the phase stays below one real minute of ticks;
- a frozen rate holds the phase;
- an accepted sync leaves the phase at zero and adopts the rate;
- minutes and hours wrap to zero and stay in their legal ranges;
- an out-of-range sync saturates;
- a hidden sync leaves the identity untouched.

Only the bench's scenarios can show the arithmetic. That covers the count of minutes after a number of ticks at every rate from 0 to 127, carried through the hour and day rollovers for both the power-of-two and the general accumulator variant. The bench scenarios also cover a tick discarded when it coincides with a sync, the encoded read-back values and the identity flags.

// File: rtl/fcf_pkg.sv
package fcf_pkg;
   localparam int MIN_PER_HOUR = 60;
   localparam int HOUR_PER_DAY = 24;
   localparam int CTL_VALID_BIT = 6;
   localparam logic [6:0] PC_ID_HIGH = 7'h7F;

   typedef logic [7:0] enc_byte_t;

   // 256-minus mapping, the same operation in both directions
   function automatic enc_byte_t neg256(input enc_byte_t b);
      return 8'(8'd0 - b);
   endfunction
endpackage

// File: rtl/fcf_phase_acc.sv
module fcf_phase_acc #(
   parameter int TICKS_PER_MIN = 60000,
   parameter int RATE_W        = 7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              clear_i,
   input  logic [RATE_W-1:0] rate_i,
   output logic              step_o
);
   localparam int PH_W = $clog2(TICKS_PER_MIN + (2 ** RATE_W));
   localparam logic [PH_W-1:0] LIMIT = PH_W'(TICKS_PER_MIN);
   localparam bit IS_POW2 = (TICKS_PER_MIN & (TICKS_PER_MIN - 1)) == 0;

   if (TICKS_PER_MIN < (2 ** RATE_W)) begin : g_bad_limit
      $fatal(1, "TICKS_PER_MIN must exceed the largest rate");
   end

   logic [PH_W-1:0] phase_q;
   logic [PH_W-1:0] sum;
   logic [PH_W-1:0] rem;
   logic            over;
   logic            advance;

   assign sum     = phase_q + PH_W'(rate_i);
   assign advance = tick_i && !clear_i && (rate_i != '0);

   if (IS_POW2) begin : g_pow2
      localparam int LOG_T = $clog2(TICKS_PER_MIN);
      // sum < 2*T, so the carry bit alone flags a full minute
      assign over = sum[LOG_T];
      assign rem  = sum & PH_W'(TICKS_PER_MIN - 1);
   end else begin : g_cmp
      assign over = (sum >= LIMIT);
      assign rem  = sum - LIMIT;
   end

   assign step_o = advance && over;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= '0;
      end else if (clear_i) begin
         phase_q <= '0;
      end else if (advance) begin
         phase_q <= over ? rem : sum;
      end
   end

   AST_PHASE_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      phase_q < LIMIT); // R2
   AST_FROZEN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && !clear_i && rate_i == '0) |=> $stable(phase_q)); // R3
   AST_SYNC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (phase_q == '0)); // R6
endmodule

// File: rtl/fcf_enc_wrap.sv
module fcf_enc_wrap
   import fcf_pkg::*;
#(
   parameter int MOD = 60
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      load_i,
   input  enc_byte_t load_enc_i,
   input  logic      step_i,
   output enc_byte_t enc_o,
   output enc_byte_t bin_o,
   output logic      wrap_o
);
   if (MOD < 2 || MOD > 128) begin : g_bad_mod
      $fatal(1, "MOD must lie in 2..128");
   end

   localparam enc_byte_t LAST_BIN = 8'(MOD - 1);
   localparam enc_byte_t LAST_ENC = 8'(256 - (MOD - 1));

   enc_byte_t enc_q;
   enc_byte_t load_bin;
   logic      at_last;

   assign bin_o    = neg256(enc_q);
   assign load_bin = neg256(load_enc_i);
   assign at_last  = (bin_o == LAST_BIN);
   assign wrap_o   = step_i && at_last;
   assign enc_o    = enc_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         enc_q <= '0;
      end else if (load_i) begin
         enc_q <= (load_bin > LAST_BIN) ? LAST_ENC : load_enc_i;
      end else if (step_i) begin
         // one value up is one encoded count down
         enc_q <= at_last ? 8'd0 : enc_q - 8'd1;
      end
   end

   AST_VALUE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bin_o <= LAST_BIN); // R8
   AST_WRAPS_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !load_i && at_last) |=> (enc_o == 8'd0)); // R4
   AST_LOAD_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && load_bin > LAST_BIN) |=> (bin_o == LAST_BIN)); // R8
endmodule

// File: rtl/fast_clock_follower.sv
module fast_clock_follower
   import fcf_pkg::*;
#(
   parameter int TICKS_PER_MIN = 60000,
   parameter int RATE_W        = 7,
   parameter int DAY_W         = 7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              sync_vld_i,
   input  logic [RATE_W-1:0] sync_rate_i,
   input  logic [7:0]        sync_min_enc_i,
   input  logic [7:0]        sync_hr_enc_i,
   input  logic [DAY_W-1:0]  sync_day_i,
   input  logic [7:0]        sync_ctl_i,
   input  logic [6:0]        sync_id_lo_i,
   input  logic [6:0]        sync_id_hi_i,
   output logic [RATE_W-1:0] rate_o,
   output logic [5:0]        minute_o,
   output logic [4:0]        hour_o,
   output logic [DAY_W-1:0]  day_o,
   output logic [7:0]        min_enc_o,
   output logic [7:0]        hr_enc_o,
   output logic [6:0]        id_lo_o,
   output logic [6:0]        id_hi_o,
   output logic              never_set_o,
   output logic              pc_setter_o
);
   if (RATE_W < 1 || RATE_W > 7) begin : g_bad_rate
      $fatal(1, "RATE_W must lie in 1..7");
   end
   if (DAY_W < 1) begin : g_bad_day
      $fatal(1, "DAY_W must be positive");
   end

   logic              accept;
   logic              min_step;
   logic              hr_step;
   logic              day_step;
   logic [RATE_W-1:0] rate_q;
   logic [DAY_W-1:0]  day_q;
   logic [6:0]        id_lo_q;
   logic [6:0]        id_hi_q;
   enc_byte_t         min_bin;
   enc_byte_t         hr_bin;
   logic              unused_ctl_bits;

   assign accept          = sync_vld_i && sync_ctl_i[CTL_VALID_BIT];
   assign unused_ctl_bits = ^{sync_ctl_i[7], sync_ctl_i[5:0], min_bin[7:6], hr_bin[7:5]};

   fcf_phase_acc #(.TICKS_PER_MIN(TICKS_PER_MIN), .RATE_W(RATE_W)) u_phase (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .clear_i(accept),
      .rate_i (rate_q),
      .step_o (min_step)
   );

   fcf_enc_wrap #(.MOD(MIN_PER_HOUR)) u_minute (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (accept),
      .load_enc_i(sync_min_enc_i),
      .step_i    (min_step),
      .enc_o     (min_enc_o),
      .bin_o     (min_bin),
      .wrap_o    (hr_step)
   );

   fcf_enc_wrap #(.MOD(HOUR_PER_DAY)) u_hour (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (accept),
      .load_enc_i(sync_hr_enc_i),
      .step_i    (hr_step),
      .enc_o     (hr_enc_o),
      .bin_o     (hr_bin),
      .wrap_o    (day_step)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rate_q  <= '0;
         day_q   <= '0;
         id_lo_q <= '0;
         id_hi_q <= '0;
      end else if (accept) begin
         rate_q  <= sync_rate_i;
         day_q   <= sync_day_i;
         id_lo_q <= sync_id_lo_i;
         id_hi_q <= sync_id_hi_i;
      end else if (day_step) begin
         day_q <= day_q + 1'b1;
      end
   end

   assign rate_o      = rate_q;
   assign day_o       = day_q;
   assign minute_o    = min_bin[5:0];
   assign hour_o      = hr_bin[4:0];
   assign id_lo_o     = id_lo_q;
   assign id_hi_o     = id_hi_q;
   assign never_set_o = (id_lo_q == 7'd0) && (id_hi_q == 7'd0);
   assign pc_setter_o = (id_hi_q == PC_ID_HIGH);

   AST_HIDDEN_SYNC_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_vld_i && !sync_ctl_i[CTL_VALID_BIT])
         |=> ($stable(id_lo_o) && $stable(id_hi_o) && $stable(rate_o))); // R7
   AST_RATE_ADOPTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept |=> (rate_o == $past(sync_rate_i))); // R6
   AST_DAY_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (day_step && !accept) |=> (day_o == $past(day_o) + 1'b1)); // R4
   AST_FROZEN_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rate_o == '0 && !accept) |=> ($stable(min_enc_o) && $stable(hr_enc_o))); // R3
endmodule

// File: tb/fast_clock_follower_bench.sv
module fast_clock_follower_bench;
   localparam int CLK_PERIOD = 10;
   localparam int T_GEN  = 200;
   localparam int T_POW2 = 128;
   localparam int DAY_W  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       svld = 1'b0;
   logic [6:0] srate = '0;
   logic [7:0] smin = '0;
   logic [7:0] shr = '0;
   logic [DAY_W-1:0] sday = '0;
   logic [7:0] sctl = '0;
   logic [6:0] sidl = '0;
   logic [6:0] sidh = '0;

   logic [6:0] rate_a, rate_b, idl_a, idh_a, idl_b, idh_b;
   logic [5:0] min_a, min_b;
   logic [4:0] hr_a, hr_b;
   logic [DAY_W-1:0] day_a, day_b;
   logic [7:0] menc_a, henc_a, menc_b, henc_b;
   logic       nev_a, pc_a, nev_b, pc_b;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   fast_clock_follower #(.TICKS_PER_MIN(T_GEN), .RATE_W(7), .DAY_W(DAY_W)) u_fast_clock_follower (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sync_vld_i(svld),
      .sync_rate_i(srate), .sync_min_enc_i(smin), .sync_hr_enc_i(shr),
      .sync_day_i(sday), .sync_ctl_i(sctl), .sync_id_lo_i(sidl), .sync_id_hi_i(sidh),
      .rate_o(rate_a), .minute_o(min_a), .hour_o(hr_a), .day_o(day_a),
      .min_enc_o(menc_a), .hr_enc_o(henc_a), .id_lo_o(idl_a), .id_hi_o(idh_a),
      .never_set_o(nev_a), .pc_setter_o(pc_a));

   fast_clock_follower #(.TICKS_PER_MIN(T_POW2), .RATE_W(7), .DAY_W(DAY_W)) u_pow2 (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sync_vld_i(svld),
      .sync_rate_i(srate), .sync_min_enc_i(smin), .sync_hr_enc_i(shr),
      .sync_day_i(sday), .sync_ctl_i(sctl), .sync_id_lo_i(sidl), .sync_id_hi_i(sidh),
      .rate_o(rate_b), .minute_o(min_b), .hour_o(hr_b), .day_o(day_b),
      .min_enc_o(menc_b), .hr_enc_o(henc_b), .id_lo_o(idl_b), .id_hi_o(idh_b),
      .never_set_o(nev_b), .pc_setter_o(pc_b));

   task automatic check(input string tag, input longint got, input longint exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic do_sync(input logic [6:0] r, input int m, input int h, input int d,
                          input logic [7:0] ctl, input logic [6:0] il, input logic [6:0] ih,
                          input logic with_tick);
      @(negedge clk);
      svld = 1'b1; srate = r; smin = 8'(256 - m); shr = 8'(256 - h);
      sday = DAY_W'(d); sctl = ctl; sidl = il; sidh = ih; tick = with_tick;
      @(negedge clk);
      svld = 1'b0; tick = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
         if (i % 3 == 2) @(negedge clk);
      end
   endtask

   // packed {day, hour, minute} after e minutes from a start time
   function automatic int model(input int m0, input int h0, input int d0, input int e);
      int tot;
      int mm;
      int hh;
      int dd;
      tot = m0 + h0 * 60 + e;
      mm = tot % 60;
      hh = (tot / 60) % 24;
      dd = (d0 + tot / 1440) % (1 << DAY_W);
      return (dd << 16) | (hh << 8) | mm;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 time", {day_a, 3'b0, hr_a, 2'b0, min_a}, 0);
      check("R1 rate", rate_a, 0);
      check("R1 enc", {menc_a, henc_a}, 0);
      check("R1 id", {idh_a, idl_a, nev_a}, 1);

      // R3 frozen after reset: ticks do nothing
      ticks(300);
      check("R3 frozen", {day_a, 3'b0, hr_a, 2'b0, min_a}, 0);

      // R5, R6, R9 sync load and encodings
      do_sync(7'd5, 59, 23, 3, 8'h40, 7'h12, 7'h34, 1'b0);
      check("R6 time", {day_a, 3'b0, hr_a, 2'b0, min_a}, (3 << 16) | (23 << 8) | 59);
      check("R6 rate", rate_a, 5);
      check("R5 enc", {menc_a, henc_a}, 16'hC5E9);
      check("R9 id", {idh_a, idl_a, nev_a, pc_a}, {7'h34, 7'h12, 2'b00});
      do_sync(7'd5, 1, 0, 3, 8'h40, 7'h00, 7'h7F, 1'b0);
      check("R5 enc min1", {menc_a, henc_a}, 16'hFF00);
      check("R9 pc", {nev_a, pc_a}, 2'b01);

      // R7 hidden sync ignored
      do_sync(7'd9, 30, 12, 7, 8'hBF, 7'h55, 7'h11, 1'b0);
      check("R7 time", {day_a, 3'b0, hr_a, 2'b0, min_a}, (3 << 16) | 1);
      check("R7 rate", rate_a, 5);
      check("R7 id", {idh_a, idl_a}, {7'h7F, 7'h00});
      check("R7 enc", {menc_a, henc_a}, 16'hFF00);

      // R8 saturation; 0x80 decodes to 128, 0x01 decodes to 255
      @(negedge clk);
      svld = 1'b1; srate = 7'd0; smin = 8'h80; shr = 8'h01; sday = '0;
      sctl = 8'h40; sidl = '0; sidh = '0;
      @(negedge clk); svld = 1'b0;
      check("R8 sat", {hr_a, 2'b0, min_a, menc_a, henc_a}, {5'd23, 2'b0, 6'd59, 16'hC5E9});
      check("R9 never", {nev_a, pc_a}, 2'b10);

      // R6 tick coinciding with sync is discarded (general variant, T=200)
      do_sync(7'd127, 0, 0, 0, 8'h40, 7'h1, 7'h1, 1'b0);
      ticks(1);
      do_sync(7'd127, 0, 0, 0, 8'h40, 7'h1, 7'h1, 1'b1);
      ticks(1);
      check("R6 discarded tick", min_a, 0);
      ticks(1);
      check("R6 next minute", min_a, 1);

      // R2 R3 R4 sweep over every rate, both accumulator variants
      for (int r = 0; r < 128; r++) begin
         int n;
         n = (r == 0) ? 40 : (3 * T_GEN) / r + 3;
         do_sync(7'(r), 58, 23, 15, 8'h40, 7'h2, 7'h3, 1'b0);
         ticks(n);
         check($sformatf("R2 R4 gen rate %0d", r),
               (day_a << 16) | (hr_a << 8) | min_a, model(58, 23, 15, (n * r) / T_GEN));
         check($sformatf("R2 R4 pow2 rate %0d", r),
               (day_b << 16) | (hr_b << 8) | min_b, model(58, 23, 15, (n * r) / T_POW2));
         check($sformatf("R5 enc rate %0d", r), {menc_a, henc_a},
               {8'(256 - (model(58, 23, 15, (n * r) / T_GEN) & 255)),
                8'(256 - ((model(58, 23, 15, (n * r) / T_GEN) >> 8) & 255))});
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule